// File: doc/BRIEF.md
# Cache-Enable Decision Unit

This unit sits between a second-level cache controller and a processor and produces one active-low cache-enable output, `cache_en_n`, for each processor bus cycle. The output tells the processor whether the line being read may be kept in its own first-level cache. The enable is withheld for writes, locked cycles and cycles the processor does not mark cacheable. It is also withheld whenever the memory side reports the address as non-cacheable. On data reads, a read-only indication also withholds it: on a miss that indication comes from the memory bus, and on a hit it comes from the tag entry of the matching line. Code reads do not look at read-only status at all.

A cycle opens when the address strobe is seen in an idle clock. The cycle attributes and the lookup result are latched at that edge. The memory-side cacheability and read-only inputs pass through a short register window. The decision is taken at the earlier of a next-address strobe or the first burst-ready, and it uses the memory values the window held at that edge. The output then stays fixed until the last burst-ready closes the cycle, and afterwards returns to its idle high level.

Top module: `cache_en_unit`

## Requirements
- R1: After reset, while no cycle is open, and while an open cycle waits for its valid point, `cache_en_n` is 1 (inactive).
- R2: A cycle opens at an edge where `cyc_start` is 1 in the idle state. Its valid point is the first later edge where `next_addr` or `burst_rdy` is 1. `cache_en_n` takes the decision right after that edge.
- R3: If the sampled memory cacheability (`mem_cacheable`, 1 = cacheable) is 0, the decision is inactive (1) for every cycle type, hits included.
- R4: If the latched cycle has `cyc_lock` = 1, or `cyc_cache_req` = 0 (processor does not request caching), the decision is inactive.
- R5: A write cycle (`cyc_write` = 1) always gets an inactive decision.
- R6: A cacheable code read (`cyc_data` = 0) gets an active decision (0), hit or miss, whatever the state of `mem_readonly` and `lkp_tag_ro`.
- R7: A cacheable data read miss (`cyc_data` = 1, `lkp_hit` = 0) is active when the sampled `mem_readonly` is 0 and inactive when it is 1.
- R8: A cacheable data read hit (`lkp_hit` = 1) is active when `lkp_tag_ro` is 0 and inactive when it is 1. `mem_readonly` has no effect.
- R9: The memory inputs used at the valid edge are the values present SAMPLE_STAGES edges earlier. A change on them at the valid edge itself does not alter the decision.
- R10: The decision holds until the edge where `burst_rdy` and `burst_last` are both 1, and is 1 after it. If the valid point is itself a last burst-ready, the decision shows for one clock and is then 1.
- R11: `cyc_start` is ignored while a cycle is open. With no open cycle, `next_addr` and `burst_rdy` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Address strobe: a processor cycle begins |
| cyc_lock | input | 1 | 1 = locked cycle |
| cyc_cache_req | input | 1 | 1 = processor requests caching |
| cyc_data | input | 1 | 1 = data access, 0 = code fetch |
| cyc_write | input | 1 | 1 = write, 0 = read |
| lkp_hit | input | 1 | 1 = lookup hit in the second-level cache |
| lkp_tag_ro | input | 1 | Read-only bit of the matching tag entry |
| mem_cacheable | input | 1 | Memory bus: 1 = address is cacheable |
| mem_readonly | input | 1 | Memory bus: 1 = address is read-only |
| next_addr | input | 1 | Next-address strobe |
| burst_rdy | input | 1 | Burst-ready strobe, one per transfer |
| burst_last | input | 1 | Qualifies `burst_rdy` as the last transfer of the cycle |
| cache_en_n | output | 1 | Cache enable to the processor, active low |

## Verification
The bench builds two copies of the unit side by side from the same stimulus: one with SAMPLE_STAGES = 1 and one with SAMPLE_STAGES = 3. The one-stage copy shows that a memory-input change at the valid edge itself stays out of the decision. The three-stage copy shows that a deeper window gives the same answers when the memory inputs are settled early. Driving both copies with identical strobes also reaches every ordering of the valid point: next-address first, burst-ready first, and a single-transfer cycle whose first ready is also its last.

// File: rtl/cen_pkg.sv
`timescale 1ns/1ps
package cen_pkg;

  typedef struct packed {
    logic locked;
    logic proc_req;
    logic is_data;
    logic is_write;
    logic hit;
    logic tag_ro;
  } cyc_attr_t;

  typedef struct packed {
    logic cacheable;
    logic read_only;
  } mem_view_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_t;

  // Active-high grant; the top inverts it onto the active-low pin.
  function automatic logic grant_enable(cyc_attr_t a, mem_view_t m);
    logic g;
    if (a.is_write || a.locked || !a.proc_req || !m.cacheable)
      g = 1'b0;
    else if (!a.is_data)
      g = 1'b1;
    else if (a.hit)
      g = !a.tag_ro;
    else
      g = !m.read_only;
    return g;
  endfunction

endpackage

// File: rtl/cen_attr_latch.sv
`timescale 1ns/1ps
module cen_attr_latch
  import cen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  cyc_attr_t attr_in,
  output cyc_attr_t attr_out
);

  cyc_attr_t attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      attr_q <= '0;
    else if (capture)
      attr_q <= attr_in;
  end

  assign attr_out = attr_q;

endmodule

// File: rtl/cen_mem_window.sv
`timescale 1ns/1ps
module cen_mem_window
  import cen_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  mem_view_t din,
  output mem_view_t dout
);

  localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

  mem_view_t [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/cen_phase_fsm.sv
`timescale 1ns/1ps
module cen_phase_fsm
  import cen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   next_addr,
  input  logic   burst_rdy,
  input  logic   burst_last,
  output phase_t phase,
  output logic   accept,
  output logic   valid_evt,
  output logic   end_evt
);

  phase_t phase_q, phase_d;
  logic   last_rdy;

  assign last_rdy  = burst_rdy && burst_last;
  assign accept    = (phase_q == PH_IDLE) && cyc_start;
  assign valid_evt = (phase_q == PH_WAIT) && (next_addr || burst_rdy);
  assign end_evt   = (phase_q == PH_HOLD) && last_rdy;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (cyc_start) phase_d = PH_WAIT;
      PH_WAIT:  if (next_addr || burst_rdy)
                  phase_d = last_rdy ? PH_DRAIN : PH_HOLD;
      PH_HOLD:  if (last_rdy) phase_d = PH_IDLE;
      PH_DRAIN: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/cache_en_unit.sv
`timescale 1ns/1ps
module cache_en_unit
  import cen_pkg::*;
#(
  parameter int SAMPLE_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_lock,
  input  logic cyc_cache_req,
  input  logic cyc_data,
  input  logic cyc_write,
  input  logic lkp_hit,
  input  logic lkp_tag_ro,
  input  logic mem_cacheable,
  input  logic mem_readonly,
  input  logic next_addr,
  input  logic burst_rdy,
  input  logic burst_last,
  output logic cache_en_n
);

  cyc_attr_t attr_in, attr_cur;
  mem_view_t mem_in, mem_win;
  phase_t    phase;
  logic      accept, valid_evt, end_evt;

  // Named events for the checker
  logic in_idle, in_wait, in_hold, in_drain;
  logic attr_write, attr_locked, attr_preq, attr_data;
  logic win_cacheable, dec_enable;

  assign attr_in = '{locked:   cyc_lock,
                     proc_req: cyc_cache_req,
                     is_data:  cyc_data,
                     is_write: cyc_write,
                     hit:      lkp_hit,
                     tag_ro:   lkp_tag_ro};
  assign mem_in  = '{cacheable: mem_cacheable, read_only: mem_readonly};

  cen_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .next_addr  (next_addr),
    .burst_rdy  (burst_rdy),
    .burst_last (burst_last),
    .phase      (phase),
    .accept     (accept),
    .valid_evt  (valid_evt),
    .end_evt    (end_evt)
  );

  cen_attr_latch u_attr (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .attr_in  (attr_in),
    .attr_out (attr_cur)
  );

  cen_mem_window #(.STAGES(SAMPLE_STAGES)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mem_in),
    .dout  (mem_win)
  );

  assign in_idle       = (phase == PH_IDLE);
  assign in_wait       = (phase == PH_WAIT);
  assign in_hold       = (phase == PH_HOLD);
  assign in_drain      = (phase == PH_DRAIN);
  assign attr_write    = attr_cur.is_write;
  assign attr_locked   = attr_cur.locked;
  assign attr_preq     = attr_cur.proc_req;
  assign attr_data     = attr_cur.is_data;
  assign win_cacheable = mem_win.cacheable;
  assign dec_enable    = grant_enable(attr_cur, mem_win);

  logic en_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_n_q <= 1'b1;
    else if (valid_evt)
      en_n_q <= !dec_enable;
    else if (end_evt || in_drain)
      en_n_q <= 1'b1;
  end

  assign cache_en_n = en_n_q;

endmodule

// File: rtl/cen_check.sv
`timescale 1ns/1ps
module cen_check (
  input logic clk,
  input logic rst_n,
  input logic in_idle,
  input logic in_wait,
  input logic in_hold,
  input logic in_drain,
  input logic valid_evt,
  input logic end_evt,
  input logic attr_write,
  input logic attr_locked,
  input logic attr_preq,
  input logic attr_data,
  input logic win_cacheable,
  input logic cyc_start,
  input logic next_addr,
  input logic burst_rdy,
  input logic cache_en_n
);

  // R1
  idle_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle || in_wait) |-> cache_en_n);

  // R2
  wait_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !next_addr && !burst_rdy) |=> (in_wait && cache_en_n));

  // R3
  mem_noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_evt && !win_cacheable) |=> cache_en_n);

  // R4
  proc_noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_evt && (attr_locked || !attr_preq)) |=> cache_en_n);

  // R5
  write_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_evt && attr_write) |=> cache_en_n);

  // R6
  code_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_evt && win_cacheable && attr_preq && !attr_locked && !attr_write && !attr_data)
    |=> !cache_en_n);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !end_evt) |=> $stable(cache_en_n));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt || in_drain) |=> (cache_en_n && in_idle));

  // R11
  stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !cyc_start) |=> (in_idle && cache_en_n));

endmodule

bind cache_en_unit cen_check u_cen_check (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_idle       (in_idle),
  .in_wait       (in_wait),
  .in_hold       (in_hold),
  .in_drain      (in_drain),
  .valid_evt     (valid_evt),
  .end_evt       (end_evt),
  .attr_write    (attr_write),
  .attr_locked   (attr_locked),
  .attr_preq     (attr_preq),
  .attr_data     (attr_data),
  .win_cacheable (win_cacheable),
  .cyc_start     (cyc_start),
  .next_addr     (next_addr),
  .burst_rdy     (burst_rdy),
  .cache_en_n    (cache_en_n)
);

// File: tb/test_cache_en_unit.sv
`timescale 1ns/1ps
module test_cache_en_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, cyc_lock = 0, cyc_cache_req = 0, cyc_data = 0, cyc_write = 0;
  logic lkp_hit = 0, lkp_tag_ro = 0, mem_cacheable = 0, mem_readonly = 0;
  logic next_addr = 0, burst_rdy = 0, burst_last = 0;
  logic en_n_a, en_n_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  exp;
    string req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  cache_en_unit #(.SAMPLE_STAGES(1)) i_cache_en_unit (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_lock(cyc_lock),
    .cyc_cache_req(cyc_cache_req), .cyc_data(cyc_data), .cyc_write(cyc_write),
    .lkp_hit(lkp_hit), .lkp_tag_ro(lkp_tag_ro), .mem_cacheable(mem_cacheable),
    .mem_readonly(mem_readonly), .next_addr(next_addr), .burst_rdy(burst_rdy),
    .burst_last(burst_last), .cache_en_n(en_n_a));

  cache_en_unit #(.SAMPLE_STAGES(3)) i_cache_en_unit_deep (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_lock(cyc_lock),
    .cyc_cache_req(cyc_cache_req), .cyc_data(cyc_data), .cyc_write(cyc_write),
    .lkp_hit(lkp_hit), .lkp_tag_ro(lkp_tag_ro), .mem_cacheable(mem_cacheable),
    .mem_readonly(mem_readonly), .next_addr(next_addr), .burst_rdy(burst_rdy),
    .burst_last(burst_last), .cache_en_n(en_n_b));

  // Expected pin level, written from the requirements (active low).
  function automatic logic expect_pin(logic lk, logic cr, logic dt, logic wr,
                                      logic ht, logic tr, logic mc, logic mro);
    logic allowed, readonly;
    allowed  = mc & cr & ~lk & ~wr;           // R3 R4 R5
    readonly = dt & (ht ? tr : mro);          // R6 R7 R8
    return ~(allowed & ~readonly);
  endfunction

  task automatic compare(input logic exp, input string req);
    checks++;
    if (en_n_a !== exp || en_n_b !== exp) begin
      errors++;
      $display("FAIL %s: cache_en_n actual %b/%b expected %b", req, en_n_a, en_n_b, exp);
    end
  endtask

  // Monitor: one expected item per edge, checked just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        compare(it.exp, it.req);
      end
    end
  end

  task automatic push(input logic exp, input string req);
    item_t it;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic run_cyc(input logic lk, input logic cr, input logic dt, input logic wr,
                         input logic ht, input logic tr, input logic mc, input logic mro,
                         input int dly, input bit use_na, input int beats,
                         input bit late, input bit intrude, input string req);
    logic e;
    int   first;
    e = expect_pin(lk, cr, dt, wr, ht, tr, mc, mro);
    mem_cacheable = mc;
    mem_readonly  = mro;
    repeat (4) @(negedge clk);
    cyc_lock = lk; cyc_cache_req = cr; cyc_data = dt; cyc_write = wr;
    lkp_hit = ht; lkp_tag_ro = tr;
    cyc_start = 1'b1;
    push(1'b1, "R1");
    @(negedge clk);
    cyc_start = 1'b0;
    // Attributes move after the start edge; the latched copy must rule.
    cyc_lock = 0; cyc_cache_req = 1; cyc_data = 0; cyc_write = 0;
    lkp_hit = 0; lkp_tag_ro = 0;
    for (int i = 1; i < dly; i++) begin
      push(1'b1, "R2");
      @(negedge clk);
    end
    if (late) begin
      mem_cacheable = ~mc;
      mem_readonly  = ~mro;
    end
    if (use_na) next_addr = 1'b1;
    else begin
      burst_rdy  = 1'b1;
      burst_last = (beats == 1);
    end
    push(e, req);
    @(negedge clk);
    next_addr = 0; burst_rdy = 0; burst_last = 0;
    mem_cacheable = mc; mem_readonly = mro;
    first = use_na ? 0 : 1;
    if (!use_na && beats == 1) begin
      push(1'b1, "R10");
      @(negedge clk);
    end
    for (int b = first; b < beats; b++) begin
      burst_rdy  = 1'b1;
      burst_last = (b == beats - 1);
      if (intrude && b == first) cyc_start = 1'b1;
      push((b == beats - 1) ? 1'b1 : e, "R10");
      @(negedge clk);
      burst_rdy = 0; burst_last = 0; cyc_start = 0;
    end
    // Stray strobes with no open cycle must do nothing.
    next_addr = 1'b1;
    burst_rdy = 1'b1;
    push(1'b1, "R11");
    @(negedge clk);
    next_addr = 0; burst_rdy = 0;
    push(1'b1, "R11");
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b1, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare(1'b1, "R1");

    //      lk cr dt wr ht tr mc mro dly na beats late intr
    run_cyc(0, 1, 0, 0, 0, 0, 1, 0,  2, 1, 4, 0, 0, "R6 code miss");
    run_cyc(0, 1, 0, 0, 1, 1, 1, 1,  1, 0, 4, 0, 0, "R6 code hit ro");
    run_cyc(0, 1, 1, 0, 0, 0, 1, 0,  3, 1, 2, 0, 0, "R7 data miss rw");
    run_cyc(0, 1, 1, 0, 0, 0, 1, 1,  2, 0, 3, 0, 0, "R7 data miss ro");
    run_cyc(0, 1, 1, 0, 1, 0, 1, 1,  1, 1, 4, 0, 0, "R8 hit tag rw");
    run_cyc(0, 1, 1, 0, 1, 1, 1, 0,  2, 1, 4, 0, 0, "R8 hit tag ro");
    run_cyc(0, 1, 0, 0, 1, 0, 0, 0,  2, 1, 2, 0, 0, "R3 mem noncache");
    run_cyc(0, 1, 1, 0, 1, 0, 0, 0,  1, 0, 2, 0, 0, "R3 mem noncache hit");
    run_cyc(0, 0, 0, 0, 0, 0, 1, 0,  2, 1, 2, 0, 0, "R4 proc noncache");
    run_cyc(1, 1, 1, 0, 1, 0, 1, 0,  2, 0, 2, 0, 0, "R4 locked");
    run_cyc(0, 1, 1, 1, 1, 0, 1, 0,  2, 1, 3, 0, 0, "R5 write");
    run_cyc(0, 1, 1, 0, 0, 0, 1, 0,  3, 1, 2, 1, 0, "R9 late change");
    run_cyc(0, 1, 0, 0, 0, 0, 1, 0,  2, 0, 2, 1, 0, "R9 late noncache");
    run_cyc(0, 1, 0, 0, 0, 0, 1, 0,  2, 0, 1, 0, 0, "R10 single beat");
    run_cyc(0, 1, 1, 0, 0, 0, 1, 0,  1, 0, 1, 0, 0, "R10 single beat data");
    run_cyc(0, 1, 1, 1, 0, 0, 1, 0,  2, 1, 3, 0, 1, "R11 start ignored");
    run_cyc(0, 1, 1, 1, 0, 0, 1, 0,  1, 0, 2, 0, 1, "R11 start on last");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule